// File: doc/BRIEF.md
# Global-History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved outcomes. That history alone, with no address bits mixed in, selects one entry in a table of 2-bit saturating counters. The table therefore learns repeating outcome patterns instead of individual branch locations. The lookup is combinational from the registered history. The caller reads the guess together with the index that produced it, and later hands that index back with the real outcome.

Both the history length and the table depth come from one parameter, `HIST_W`, and the table holds 2^`HIST_W` counters. A 16-bit history gives 65536 counters. The default is smaller so that elaboration stays light, and the behaviour is the same at every width. After reset the block walks through the table once, writing every counter, and it holds `busy` high while it does so.

Top module: `ghp_predictor`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2^HIST_W rising clock edges and is low from then on, until the next reset.
- R2: When `busy` falls, the history is zero and every counter holds 1 (weakly not taken), so every index predicts not taken.
- R3: `pred_taken` is 1 when the counter at `pred_idx` holds 2 or 3, and 0 when it holds 0 or 1. The encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken.
- R4: An accepted update with `upd_taken`=1 raises the addressed counter by one, and a counter at 3 stays at 3.
- R5: An accepted update with `upd_taken`=0 lowers the addressed counter by one, and a counter at 0 stays at 0.
- R6: An accepted update shifts the history left by one, puts `upd_taken` into bit 0, drops the top bit, and shows the new value on `pred_idx` after that edge.
- R7: An update changes only the counter that `upd_idx` selects, whatever the current history is.
- R8: While `busy` is high, `upd_valid` is ignored: `pred_idx` stays 0 and no counter is changed by the update.
- R9: Without an accepted update, the history and `pred_idx` keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | output | 1 | Table initialisation in progress |
| pred_idx | output | HIST_W | Current history, the table index used for the guess |
| pred_taken | output | 1 | Guess for the next branch, 1 = taken |
| upd_valid | input | 1 | A resolved outcome is presented this cycle |
| upd_idx | input | HIST_W | Index that was returned with the guess for this branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check on every cycle that the length of the initialisation window is correct, that `pred_idx` stays at zero while it lasts, that the history shifts correctly on each accepted update and holds otherwise. Counter contents are visible only through `pred_taken` once the history points at them, so only the bench's scenarios show them. These scenarios cover saturation at both ends, a write to an index other than the current history, a reset in the middle of a run with updates arriving during the sweep, and a long random stream compared against a reference model.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

    // 2-bit direction counter, upper bit is the guess
    typedef enum logic [1:0] {
        CNT_SNT = 2'd0,
        CNT_WNT = 2'd1,
        CNT_WT  = 2'd2,
        CNT_ST  = 2'd3
    } cnt_t;

    localparam cnt_t CNT_INIT = CNT_WNT;

    function automatic cnt_t cnt_step(cnt_t cur, logic taken);
        cnt_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CNT_ST) nxt = cnt_t'(cur + 2'd1);
        end else begin
            if (cur != CNT_SNT) nxt = cnt_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ghp_ctrl.sv
module ghp_ctrl #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_taken,
    output logic              busy,
    output logic [HIST_W-1:0] hist,
    output logic              init_we,
    output logic [HIST_W-1:0] init_addr,
    output logic              upd_en
);

    localparam logic [HIST_W-1:0] SWEEP_LAST = '1;

    typedef struct packed {
        logic              busy;
        logic [HIST_W-1:0] hist;
        logic [HIST_W-1:0] sweep;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.sweep = st_q.sweep + 1'b1;
            if (st_q.sweep == SWEEP_LAST) begin
                st_d.busy = 1'b0;
            end
        end else if (upd_valid) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b1;
            st_q.hist  <= '0;
            st_q.sweep <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign hist      = st_q.hist;
    assign init_we   = st_q.busy;
    assign init_addr = st_q.sweep;
    assign upd_en    = upd_valid & ~st_q.busy;

endmodule

// File: rtl/ghp_table.sv
module ghp_table
    import ghp_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              init_we,
    input  logic [HIST_W-1:0] init_addr,
    input  logic              upd_we,
    input  logic [HIST_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] rd_addr,
    output cnt_t              rd_cnt
);

    localparam int DEPTH = 1 << HIST_W;

    typedef struct packed {
        logic              en;
        logic [HIST_W-1:0] addr;
        cnt_t              val;
    } wr_t;

    cnt_t mem_q [DEPTH];
    wr_t  wr_d;

    // initialisation sweep has the write port first
    always_comb begin
        wr_d = '{en: 1'b0, addr: '0, val: CNT_INIT};
        if (init_we) begin
            wr_d.en   = 1'b1;
            wr_d.addr = init_addr;
            wr_d.val  = CNT_INIT;
        end else if (upd_we) begin
            wr_d.en   = 1'b1;
            wr_d.addr = upd_addr;
            wr_d.val  = cnt_step(mem_q[upd_addr], upd_taken);
        end
    end

    // storage only: contents are set by the sweep, not by reset
    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem_q[wr_d.addr] <= wr_d.val;
        end
    end

    assign rd_cnt = mem_q[rd_addr];

endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor
    import ghp_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              busy,
    output logic [HIST_W-1:0] pred_idx,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken
);

    logic [HIST_W-1:0] hist;
    logic              init_we;
    logic [HIST_W-1:0] init_addr;
    logic              upd_en;
    cnt_t              rd_cnt;

    ghp_ctrl #(.HIST_W(HIST_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .busy      (busy),
        .hist      (hist),
        .init_we   (init_we),
        .init_addr (init_addr),
        .upd_en    (upd_en)
    );

    ghp_table #(.HIST_W(HIST_W)) u_table (
        .clk       (clk),
        .init_we   (init_we),
        .init_addr (init_addr),
        .upd_we    (upd_en),
        .upd_addr  (upd_idx),
        .upd_taken (upd_taken),
        .rd_addr   (hist),
        .rd_cnt    (rd_cnt)
    );

    assign pred_idx   = hist;
    assign pred_taken = rd_cnt[1];

endmodule

// File: rtl/ghp_predictor_chk.sv
module ghp_predictor_chk #(
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [HIST_W-1:0] pred_idx,
    input logic              upd_valid,
    input logic              upd_taken
);

    localparam int unsigned DEPTH = 1 << HIST_W;
    localparam logic [HIST_W:0] DEPTH_C = DEPTH[HIST_W:0];

    logic [HIST_W:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q < DEPTH_C) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R1
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (cyc_q < DEPTH_C));

    // R8
    busy_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pred_idx == '0);

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !busy) |=>
            pred_idx == {$past(pred_idx[HIST_W-2:0]), $past(upd_taken)});

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || busy) |=> $stable(pred_idx));

endmodule

bind ghp_predictor ghp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pred_idx  (pred_idx),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken)
);

// File: tb/tb_ghp_predictor.sv
`timescale 1ns/1ps
module tb_ghp_predictor;

    localparam int HW    = 6;
    localparam int DEPTH = 1 << HW;
    localparam logic [HW-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          busy;
    logic [HW-1:0] pred_idx;
    logic          pred_taken;
    logic          upd_valid;
    logic [HW-1:0] upd_idx;
    logic          upd_taken;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int ref_tbl [DEPTH];
    int ref_hist = 0;
    int ref_busy = DEPTH;

    always #5 clk = ~clk;

    ghp_predictor #(.HIST_W(HW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .pred_idx   (pred_idx),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx),
        .upd_taken  (upd_taken)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_hist = 0;
            ref_busy = DEPTH;
            for (int i = 0; i < DEPTH; i++) ref_tbl[i] = 1;
        end else if (ref_busy > 0) begin
            ref_busy--;
        end else if (upd_valid) begin
            if (upd_taken) begin
                if (ref_tbl[upd_idx] < 3) ref_tbl[upd_idx]++;
            end else begin
                if (ref_tbl[upd_idx] > 0) ref_tbl[upd_idx]--;
            end
            ref_hist = ((ref_hist << 1) | int'(upd_taken)) & (DEPTH - 1);
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R1 busy", int'(busy), int'(ref_busy > 0));
            if (ref_busy == 0) begin
                chk("R6 pred_idx", int'(pred_idx), ref_hist);
                chk("R3 pred_taken", int'(pred_taken), int'(ref_tbl[ref_hist] >= 2));
            end
        end
    end

    task automatic upd(logic [HW-1:0] idx, logic t);
        upd_valid = 1'b1;
        upd_idx   = idx;
        upd_taken = t;
        @(negedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; upd_valid = 1'b0; upd_idx = '0; upd_taken = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        chk("R1 busy at release", int'(busy), 1);
        repeat (DEPTH - 1) @(negedge clk);
        #1 chk("R1 busy before last edge", int'(busy), 1);
        @(negedge clk); #1;
        chk("R1 busy dropped", int'(busy), 0);
        chk("R2 idx zero", int'(pred_idx), 0);
        chk("R2 not taken", int'(pred_taken), 0);

        // R5: history stays 0 under not-taken, counter 0 floors at 0
        upd('0, 1'b0); upd('0, 1'b0); upd('0, 1'b0);
        chk("R5 floor", int'(pred_taken), 0);
        chk("R9 idx stays 0", int'(pred_idx), 0);

        // R6: fill history with ones
        for (int i = 0; i < HW; i++) upd(pred_idx, 1'b1);
        chk("R6 all ones", int'(pred_idx), int'(ALL1));
        chk("R2 fresh counter", int'(pred_taken), 0);
        upd(ALL1, 1'b1);
        chk("R3 weak taken", int'(pred_taken), 1);
        upd(ALL1, 1'b1); upd(ALL1, 1'b1);
        chk("R4 ceiling", int'(pred_taken), 1);

        // R7: train index ALL1-1 while history sits at ALL1
        upd(ALL1 - 1'b1, 1'b1); upd(ALL1 - 1'b1, 1'b1);
        chk("R7 history held", int'(pred_idx), int'(ALL1));
        upd(ALL1, 1'b0);
        chk("R7 idx", int'(pred_idx), int'(ALL1 - 1'b1));
        chk("R7 other counter trained", int'(pred_taken), 1);

        // random stream
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) != 0) begin
                upd(($urandom_range(0, 3) == 0) ? HW'($urandom) : pred_idx,
                    1'($urandom));
            end else begin
                @(negedge clk); #1;
            end
        end

        // R8: reset mid-run, updates during sweep are ignored
        rst_n = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        upd_valid = 1'b1; upd_taken = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            upd_idx = HW'(i);
            @(negedge clk); #1;
            if (i < DEPTH - 1) chk("R8 idx during busy", int'(pred_idx), 0);
        end
        upd_valid = 1'b0;
        chk("R8 busy done", int'(busy), 0);
        chk("R8 idx untouched", int'(pred_idx), 0);
        chk("R8 counter untouched", int'(pred_taken), 0);

        for (int i = 0; i < 200; i++) upd(pred_idx, 1'($urandom));
        @(negedge clk); #1;
        finish_run();
    end

endmodule